// File: doc/BRIEF.md
# Synchronous SRAM Byte-Lane Write Controller

This block turns the write-control pins of a four-lane synchronous SRAM into one write strobe per byte lane. It also decides when each write lands, which depends on the strobe that opened the access. An access opened by the processor strobe is a two-cycle write. The write pins are not looked at in the opening cycle. They are sampled in the following cycle, and the core is written at the clock edge that ends that cycle. An access opened by the controller strobe is a one-cycle write. Its write pins are sampled in the same cycle, and the core is written at the edge that closes it.

A global write stores every lane whatever the byte selects say. Without a global write, the byte-write enable together with the per-lane selects picks the lanes to store. A small register array stands in for the memory core, so results can be read back through the ordinary read access. A write-cycle flag rises in every cycle that writes the core, so that shared data drivers can be turned off.

Top module: `sram_write_ctrl`

## Requirements
- R1: With `gw_n` low in a cycle that writes, all four lanes are written, whatever `bwe_n` and `bsel_n` are.
- R2: With `gw_n` high and `bwe_n` low, exactly the lanes whose `bsel_n` bit is low are written. Bit k selects lane k, which is `wdata[8k+7:8k]`. With both `gw_n` and `bwe_n` high, no lane is written.
- R3: During a byte write, lanes that are not selected keep their previous contents.
- R4: When the processor strobe (`adsp_n` low) opens an access, `lane_we` is zero in that cycle, whatever the write pins are. In the next cycle the write pins decide the lanes, and the data is stored at the address captured in the opening cycle.
- R5: The controller strobe (`adsc_n` low, `adsp_n` high, chip selected) writes in the same cycle, at the address presented in that cycle.
- R6: No access starts unless `ce1_n` is low, `ce2` is high and `ce3_n` is low. If any one of them is inactive, both strobes are ignored: there is no write then and no write in the next cycle.
- R7: An access opened with `gw_n` and `bwe_n` both high is a read. `rdata` shows the addressed word after the next clock edge and keeps its value until the next read.
- R8: `wr_cycle` is high exactly in the cycles where at least one bit of `lane_we` is high.
- R9: When both strobes are low in a selected cycle, the access is treated as opened by the processor strobe.
- R10: A controller-strobe access presented in the completion cycle of a processor-strobe write is ignored. Only the completing write takes place.
- R11: While `rst` is high, the array and `rdata` are cleared and any pending second cycle is dropped. After reset `lane_we` and `wr_cycle` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| addr | input | AW | Word address |
| wdata | input | 4*LANE_W | Write data, lane k in bits [LANE_W*k +: LANE_W] |
| lane_we | output | 4 | Per-lane write strobes to the core |
| wr_cycle | output | 1 | High in any cycle that writes the core |
| rdata | output | 4*LANE_W | Registered read data |

## Verification
The stimulus table opens accesses with the global write and with each kind of byte write. This separates the R1 override from R2 lane selection, and a partial select read back afterwards shows that unselected lanes are preserved. The bench puts processor-strobe and controller-strobe accesses side by side with the same write pins. This shows the quiet opening cycle and the delayed, captured-address write of the first against the same-cycle write of the second. Each chip enable is dropped on its own. The corner patterns cover both strobes low together and a controller strobe that collides with a completion cycle. For every case the bench reads the stored words back, which shows where each write actually landed.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    localparam int NUM_LANES = 4;

    typedef logic [NUM_LANES-1:0] lane_mask_t;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic proc_go;    // processor strobe opens an access
        logic ctrl_go;    // controller strobe opens an access
        logic rd_intent;  // both write pins inactive
    } start_t;

    // Lane selection: global write wins, then byte-write with selects.
    function automatic lane_mask_t write_lanes(
        input logic       gw_n,
        input logic       bwe_n,
        input lane_mask_t bsel_n
    );
        if (!gw_n) begin
            return '1;
        end else if (!bwe_n) begin
            return ~bsel_n;
        end
        return '0;
    endfunction

endpackage

// File: rtl/bw_start_decode.sv
module bw_start_decode
    import sram_wr_pkg::*;
(
    input  logic   adsp_n,
    input  logic   adsc_n,
    input  logic   ce1_n,
    input  logic   ce2,
    input  logic   ce3_n,
    input  logic   gw_n,
    input  logic   bwe_n,
    output start_t st
);
    logic selected;

    always_comb begin
        selected     = !ce1_n && ce2 && !ce3_n;
        st.proc_go   = selected && !adsp_n;
        st.ctrl_go   = selected && adsp_n && !adsc_n;
        st.rd_intent = gw_n && bwe_n;
    end
endmodule

// File: rtl/bw_cycle_seq.sv
module bw_cycle_seq
    import sram_wr_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  start_t        st,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  lane_mask_t    bsel_n,
    input  logic [AW-1:0] addr,
    output lane_mask_t    we,
    output logic [AW-1:0] wr_addr,
    output logic          rd_go
);
    phase_e        phase;
    logic [AW-1:0] addr_q;

    always_comb begin
        we      = '0;
        wr_addr = addr;
        rd_go   = 1'b0;
        if (phase == PH_SECOND) begin
            // completion of a processor-strobe write; controller strobe ignored
            we      = write_lanes(gw_n, bwe_n, bsel_n);
            wr_addr = addr_q;
            rd_go   = st.proc_go && st.rd_intent;
        end else begin
            if (st.ctrl_go) begin
                we = write_lanes(gw_n, bwe_n, bsel_n);
            end
            rd_go = (st.proc_go || st.ctrl_go) && st.rd_intent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            addr_q <= '0;
        end else begin
            phase <= st.proc_go ? PH_SECOND : PH_IDLE;
            if (st.proc_go) begin
                addr_q <= addr;
            end
        end
    end
endmodule

// File: rtl/bw_lane_array.sv
module bw_lane_array
    import sram_wr_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lane_mask_t                    we,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [NUM_LANES*LANE_W-1:0]   wdata,
    input  logic                          rd_go,
    input  logic [AW-1:0]                 rd_addr,
    output logic [NUM_LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= '0;
                end
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else begin
                if (we[g]) begin
                    mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
                end
                if (rd_go) begin
                    rdata[g*LANE_W +: LANE_W] <= mem[rd_addr];
                end
            end
        end
    end
endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
    import sram_wr_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        adsp_n,
    input  logic                        adsc_n,
    input  logic                        ce1_n,
    input  logic                        ce2,
    input  logic                        ce3_n,
    input  logic                        gw_n,
    input  logic                        bwe_n,
    input  logic [3:0]                  bsel_n,
    input  logic [AW-1:0]               addr,
    input  logic [4*LANE_W-1:0]         wdata,
    output logic [3:0]                  lane_we,
    output logic                        wr_cycle,
    output logic [4*LANE_W-1:0]         rdata
);
    start_t        st;
    lane_mask_t    we;
    logic [AW-1:0] wr_addr;
    logic          rd_go;

    bw_start_decode u_dec (
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .st     (st)
    );

    bw_cycle_seq #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .addr    (addr),
        .we      (we),
        .wr_addr (wr_addr),
        .rd_go   (rd_go)
    );

    bw_lane_array #(.AW(AW), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .wr_addr (wr_addr),
        .wdata   (wdata),
        .rd_go   (rd_go),
        .rd_addr (addr),
        .rdata   (rdata)
    );

    assign lane_we  = we;
    assign wr_cycle = |we;
endmodule

// File: rtl/sram_write_ctrl_chk.sv
module sram_write_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       adsp_n,
    input logic       adsc_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       ce3_n,
    input logic       gw_n,
    input logic       bwe_n,
    input logic [3:0] bsel_n,
    input logic [3:0] lane_we,
    input logic       wr_cycle
);
    logic sel, p_go, c_go, pend_q;

    always_comb begin
        sel  = !ce1_n && ce2 && !ce3_n;
        p_go = sel && !adsp_n;
        c_go = sel && adsp_n && !adsc_n;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= p_go;
    end

    assert_adsp_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (p_go && !pend_q) |-> (lane_we == 4'b0000));

    assert_second_global_R1: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !gw_n) |-> (lane_we == 4'b1111));

    assert_ctrl_global_R5: assert property (@(posedge clk) disable iff (rst)
        (c_go && !pend_q && !gw_n) |-> (lane_we == 4'b1111));

    assert_byte_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (c_go && !pend_q && gw_n && !bwe_n) |-> (lane_we == ~bsel_n));

    assert_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        (!sel && !pend_q) |-> (lane_we == 4'b0000));

    assert_both_low_R9: assert property (@(posedge clk) disable iff (rst)
        (sel && !adsp_n && !adsc_n && !pend_q) |-> (lane_we == 4'b0000));

    assert_flag_on_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(lane_we) != 0) |-> wr_cycle);

    assert_flag_off_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(lane_we) == 0) |-> !wr_cycle);
endmodule

bind sram_write_ctrl sram_write_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .lane_we  (lane_we),
    .wr_cycle (wr_cycle)
);

// File: tb/sram_write_ctrl_test.sv
module sram_write_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        adsp_n, adsc_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
    logic [3:0]  bsel_n;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  lane_we;
    logic        wr_cycle;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_write_ctrl #(.AW(AW), .LANE_W(8)) uut (
        .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .addr(addr), .wdata(wdata),
        .lane_we(lane_we), .wr_cycle(wr_cycle), .rdata(rdata)
    );

    typedef struct packed {
        logic       adsp_n, adsc_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
        logic [3:0] bsel_n;
        logic [3:0] addr;
        logic [3:0] exp_we;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd1,  4'b1111, 4'd5},  // R5 ctrl global
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'b1010, 4'd2,  4'b0101, 4'd2},  // R2 partial
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'b1111, 4'd3,  4'b1111, 4'd1},  // R1 override
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'b0000, 4'd4,  4'b0000, 4'd2},  // R2 no enable
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd5,  4'b0000, 4'd4},  // R4 quiet open
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'b1100, 4'd9,  4'b0011, 4'd4},  // R4 second cycle
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd13, 4'b0000, 4'd6},  // R6 ce1_n
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'b1111, 4'd13, 4'b0000, 4'd6},  // R6 ce2
        '{1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1, 4'b1111, 4'd13, 4'b0000, 4'd6},  // R6 ce3_n
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd13, 4'b0000, 4'd6},  // R6 no pending
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd6,  4'b0000, 4'd9},  // R9 both low
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'b0111, 4'd14, 4'b1000, 4'd9},  // R9 completes
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'b1111, 4'd7,  4'b0000, 4'd4},  // R4 open
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1, 4'b1111, 4'd8,  4'b1111, 4'd10}, // R10 collide
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'b1111, 4'd8,  4'b0000, 4'd10}, // R10 no pending
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'b1111, 4'd10, 4'b0000, 4'd4},  // R4 open
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'b1111, 4'd10, 4'b0000, 4'd4},  // R4 no write pins
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'b1111, 4'd11, 4'b0000, 4'd2}   // R2 none selected
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'b1111; addr = '0; wdata = '0;
    endtask

    // Controller-strobe read; rdata is valid after the next rising edge.
    task automatic read_word(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        idle();
        adsc_n = 1'b0;
        addr   = a;
        @(posedge clk);
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check("R11 lane_we", {28'd0, lane_we}, 32'd0);
        check("R11 wr_cycle", {31'd0, wr_cycle}, 32'd0);
        check("R11 rdata", rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adsp_n = VEC[i].adsp_n; adsc_n = VEC[i].adsc_n;
            ce1_n  = VEC[i].ce1_n;  ce2    = VEC[i].ce2;  ce3_n = VEC[i].ce3_n;
            gw_n   = VEC[i].gw_n;   bwe_n  = VEC[i].bwe_n;
            bsel_n = VEC[i].bsel_n; addr   = VEC[i].addr;
            for (int k = 0; k < 4; k++) begin
                wdata[8*k +: 8] = 8'(i*16 + k + 1);
            end
            #1;
            check($sformatf("R%0d vec%0d lane_we", VEC[i].req, i),
                  {28'd0, lane_we}, {28'd0, VEC[i].exp_we});
            check($sformatf("R8 vec%0d wr_cycle", i),
                  {31'd0, wr_cycle}, {31'd0, |VEC[i].exp_we});
        end

        // stored words: lane k of vector i holds i*16+k+1
        read_word(4'd1,  32'h04030201, "R5 ctrl write same cycle");
        read_word(4'd2,  32'h00130011, "R3 unselected lanes kept");
        read_word(4'd3,  32'h24232221, "R1 global override");
        read_word(4'd4,  32'h00000000, "R7 read access stores nothing");
        read_word(4'd5,  32'h00005251, "R4 write at captured addr");
        read_word(4'd9,  32'h00000000, "R4 second-cycle addr unused");
        read_word(4'd6,  32'hB4000000, "R9 both strobes act as processor");
        read_word(4'd14, 32'h00000000, "R9 completion addr unused");
        read_word(4'd7,  32'hD4D3D2D1, "R10 completion write");
        read_word(4'd8,  32'h00000000, "R10 colliding ctrl ignored");
        read_word(4'd10, 32'h00000000, "R4 no write pins no write");
        read_word(4'd11, 32'h00000000, "R2 no lanes selected");
        read_word(4'd13, 32'h00000000, "R6 deselected writes dropped");

        // R7 rdata holds without a read
        read_word(4'd3, 32'h24232221, "R7 read");
        @(negedge clk);
        idle();
        addr = 4'd1;
        @(posedge clk);
        #1;
        check("R7 rdata holds", rdata, 32'h24232221);

        // R11 reset drops a pending second cycle
        @(negedge clk);
        idle();
        adsp_n = 1'b0; addr = 4'd12;
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        gw_n = 1'b0; wdata = 32'hFFFFFFFF;
        #1;
        check("R11 pending dropped", {28'd0, lane_we}, 32'd0);
        read_word(4'd12, 32'h00000000, "R11 nothing written");
        read_word(4'd1,  32'h00000000, "R11 array cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule